// File: doc/BRIEF.md
# Prime-Field Modular Adder/Subtractor

This block adds or subtracts two 255-bit elements of the prime field whose modulus is p = 2^255 - 19. The result is always fully reduced into the range [0, p). Elliptic-curve arithmetic uses such a unit to work alongside a field multiplier. A single-cycle `start` pulse captures both operands and the operation select. A single-cycle `done` pulse follows a fixed number of cycles later and marks the result as valid.

The datapath is not one wide carry chain. It handles the operands as 17 limbs of 15 bits, one limb per cycle, and keeps the carry or borrow in a register between limbs. Two chains run side by side. The first forms the raw sum or difference. The second forms that value with p taken away (for addition) or with p added (for subtraction). After the last limb, the final carries decide which of the two values becomes the result.

Top module: `fe_addsub`

## Requirements
- R1: With `op_sub` = 0, the result is (a + b) mod p. A sum that equals p gives 0, and a sum above 2^255 - 1 still reduces correctly.
- R2: With `op_sub` = 1, the result is (a - b) mod p. When a < b, p is added back in. When a = b, the result is 0.
- R3: `done` is high for exactly one cycle. That cycle is the 17th clock cycle after the cycle in which `start` was high.
- R4: `a`, `b` and `op_sub` are sampled only in the `start` cycle. Changing them while the operation runs has no effect on its result.
- R5: `result` keeps its value from one `done` pulse until the next `done` pulse. While the block is idle or busy, it does not change.
- R6: A `start` pulse that arrives while an operation is in progress abandons that operation. No `done` is produced for the abandoned operation. The next `done` follows the new `start` with the R3 latency and carries the result for the new operands.
- R7: After reset, `done` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that launches an operation |
| op_sub | input | 1 | 0 selects add, 1 selects subtract |
| a | input | 255 | First operand, field element below p |
| b | input | 255 | Second operand, field element below p |
| done | output | 1 | One-cycle pulse marking a new valid result |
| result | output | 255 | Reduced result, held between operations |

## Verification
The hardest case to reach is a final select that depends on a carry which ripples through all seventeen limbs. Examples are a sum that lands exactly on p, a sum that overflows 2^255, and a difference that falls one below zero. Each of these needs operands whose limbs are almost all ones or almost all zeros. The stimulus is therefore an all-pairs sweep over a set of boundary operands: 0, 1, 19, values next to a limb boundary, p-1, p-2, p-19, half of p and 2^254. Every pair is run in both modes, and the operand pins are scrambled right after each start. A separate sequence restarts an operation in the middle to check that the abandoned one is discarded.

// File: rtl/fe_addsub.sv
module fe_addsub #(
  parameter int LIMB_W     = 15,
  parameter int LIMBS      = 17,
  parameter int MOD_OFFSET = 19
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      op_sub,
  input  logic [LIMB_W*LIMBS-1:0]   a,
  input  logic [LIMB_W*LIMBS-1:0]   b,
  output logic                      done,
  output logic [LIMB_W*LIMBS-1:0]   result
);
  localparam int W  = LIMB_W * LIMBS;
  localparam int IW = $clog2(LIMBS);
  localparam logic [W-1:0]  MODULUS = {W{1'b1}} - W'(MOD_OFFSET - 1);
  localparam logic [IW-1:0] LAST    = IW'(LIMBS - 1);

  logic [W-1:0]      a_q, b_q, m_q, pri_q, alt_q, result_q;
  logic              op_q, busy_q, done_q, c1_q, c2_q;
  logic [IW-1:0]     idx_q;

  logic              sub_now, use_alt, last;
  logic [LIMB_W-1:0] la, lb, lm;
  logic [LIMB_W:0]   ci1, ci2, s1, s2;

  assign sub_now = start ? op_sub : op_q;
  assign la      = start ? a[LIMB_W-1:0] : a_q[LIMB_W-1:0];
  assign lb      = start ? b[LIMB_W-1:0] : b_q[LIMB_W-1:0];
  assign lm      = start ? MODULUS[LIMB_W-1:0] : m_q[LIMB_W-1:0];
  assign ci1     = {{LIMB_W{1'b0}}, (start ? 1'b0 : c1_q)};
  assign ci2     = {{LIMB_W{1'b0}}, (start ? 1'b0 : c2_q)};

  // primary chain: raw sum / difference
  assign s1 = sub_now ? ({1'b0, la} - {1'b0, lb} - ci1)
                      : ({1'b0, la} + {1'b0, lb} + ci1);
  // alternate chain: primary minus p (add) or plus p (subtract)
  assign s2 = sub_now ? ({1'b0, s1[LIMB_W-1:0]} + {1'b0, lm} + ci2)
                      : ({1'b0, s1[LIMB_W-1:0]} - {1'b0, lm} - ci2);

  assign use_alt = sub_now ? s1[LIMB_W] : (s1[LIMB_W] | ~s2[LIMB_W]);
  assign last    = busy_q && !start && (idx_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q      <= '0;
      b_q      <= '0;
      m_q      <= '0;
      pri_q    <= '0;
      alt_q    <= '0;
      result_q <= '0;
      op_q     <= 1'b0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      c1_q     <= 1'b0;
      c2_q     <= 1'b0;
      idx_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (start || busy_q) begin
        pri_q <= {s1[LIMB_W-1:0], pri_q[W-1:LIMB_W]};
        alt_q <= {s2[LIMB_W-1:0], alt_q[W-1:LIMB_W]};
        c1_q  <= s1[LIMB_W];
        c2_q  <= s2[LIMB_W];
      end
      if (start) begin
        a_q    <= a >> LIMB_W;
        b_q    <= b >> LIMB_W;
        m_q    <= MODULUS >> LIMB_W;
        op_q   <= op_sub;
        busy_q <= 1'b1;
        idx_q  <= IW'(1);
      end else if (busy_q) begin
        a_q   <= a_q >> LIMB_W;
        b_q   <= b_q >> LIMB_W;
        m_q   <= m_q >> LIMB_W;
        idx_q <= idx_q + IW'(1);
        if (last) begin
          busy_q   <= 1'b0;
          done_q   <= 1'b1;
          result_q <= use_alt ? {s2[LIMB_W-1:0], alt_q[W-1:LIMB_W]}
                              : {s1[LIMB_W-1:0], pri_q[W-1:LIMB_W]};
        end
      end
    end
  end

  assign done   = done_q;
  assign result = result_q;
endmodule

// File: rtl/fe_addsub_chk.sv
module fe_addsub_chk #(
  parameter int LIMB_W     = 15,
  parameter int LIMBS      = 17,
  parameter int MOD_OFFSET = 19
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic                    done,
  input logic [LIMB_W*LIMBS-1:0] result
);
  localparam int W = LIMB_W * LIMBS;
  localparam logic [W-1:0] MODULUS = {W{1'b1}} - W'(MOD_OFFSET - 1);

  logic [7:0] cnt_q;
  logic       live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      live_q <= 1'b0;
    end else if (start) begin
      cnt_q  <= 8'd1;
      live_q <= 1'b1;
    end else if (done) begin
      live_q <= 1'b0;
    end else if (live_q && cnt_q != 8'hFF) begin
      cnt_q <= cnt_q + 8'd1;
    end
  end

  p_result_in_field_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result < MODULUS));

  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (live_q && cnt_q == 8'(LIMBS)));

  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);
endmodule

bind fe_addsub fe_addsub_chk #(.LIMB_W(LIMB_W), .LIMBS(LIMBS), .MOD_OFFSET(MOD_OFFSET)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .result(result)
);

// File: tb/fe_addsub_bench.sv
`timescale 1ns/1ps
module fe_addsub_bench;
  localparam logic [254:0] P = {255{1'b1}} - 255'd18;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         op_sub = 1'b0;
  logic [254:0] a = '0;
  logic [254:0] b = '0;
  logic         done;
  logic [254:0] result;

  int checks = 0;
  int errors = 0;
  logic [254:0] vals [12];

  always #2 clk = ~clk;

  fe_addsub u_fe_addsub (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sub(op_sub),
    .a(a), .b(b), .done(done), .result(result)
  );

  function automatic logic [254:0] exp_val(input logic [254:0] x, input logic [254:0] y, input bit s);
    logic [255:0] t;
    if (!s) begin
      t = {1'b0, x} + {1'b0, y};
      if (t >= {1'b0, P}) t = t - {1'b0, P};
    end else if (x >= y) begin
      t = {1'b0, x} - {1'b0, y};
    end else begin
      t = {1'b0, x} + {1'b0, P} - {1'b0, y};
    end
    return t[254:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [254:0] act, input logic [254:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // launch, scramble pins (R4), watch 19 cycles for done (R3), check value (R1/R2) and hold (R5)
  task automatic do_op(input logic [254:0] x, input logic [254:0] y, input bit s);
    int hits = 0;
    int at = 0;
    logic [254:0] got = '0;
    logic [254:0] e = exp_val(x, y, s);
    @(negedge clk);
    a = x; b = y; op_sub = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0; a = ~x; b = ~y; op_sub = ~s;
    for (int n = 1; n <= 19; n++) begin
      if (done) begin
        hits++;
        if (at == 0) begin at = n; got = result; end
      end
      @(negedge clk);
    end
    chk(hits == 1 && at == 17, "R3 done latency/width", 255'(at), 255'd17);
    chk(got == e, s ? "R2 sub value (R4 pins scrambled)" : "R1 add value (R4 pins scrambled)", got, e);
    chk(result == e, "R5 result held after done", result, e);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    vals[0]  = '0;
    vals[1]  = 255'd1;
    vals[2]  = 255'd19;
    vals[3]  = 255'h7FED;
    vals[4]  = 255'h7FFF;
    vals[5]  = 255'h8000;
    vals[6]  = P - 255'd1;
    vals[7]  = P - 255'd2;
    vals[8]  = P - 255'd19;
    vals[9]  = (P - 255'd1) >> 1;
    vals[10] = 255'd1 << 254;
    vals[11] = {17{15'h5555}};

    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R7 done after reset", 255'(done), '0);
    chk(result == '0, "R7 result after reset", result, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && result == '0, "R7 idle after release", result, '0);

    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++) begin
        do_op(vals[i], vals[j], 1'b0);
        do_op(vals[i], vals[j], 1'b1);
      end

    // R5: long idle, result unchanged, no done
    begin
      logic [254:0] held = result;
      int spur = 0;
      for (int n = 0; n < 40; n++) begin
        if (done) spur++;
        @(negedge clk);
      end
      chk(result == held && spur == 0, "R5 idle hold", result, held);
    end

    // R6: restart mid-operation
    begin
      int hits = 0;
      int at = 0;
      int early = 0;
      logic [254:0] got = '0;
      logic [254:0] e = exp_val(P - 255'd1, 255'd5, 1'b0);
      a = 255'd7; b = 255'd9; op_sub = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int n = 0; n < 6; n++) begin
        if (done) early++;
        @(negedge clk);
      end
      a = P - 255'd1; b = 255'd5; op_sub = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0; a = '0; b = '0;
      for (int n = 1; n <= 24; n++) begin
        if (done) begin
          hits++;
          if (at == 0) begin at = n; got = result; end
        end
        @(negedge clk);
      end
      chk(early == 0, "R6 no done before restart", 255'(early), '0);
      chk(hits == 1 && at == 17, "R6 latency from latest start", 255'(at), 255'd17);
      chk(got == e, "R6 result of restarted operands", got, e);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule